// File: doc/BRIEF.md
# Thread Block Dispatcher

The dispatcher takes a kernel launch (a grid size counted in blocks and a block size counted in threads) and feeds the block indices of that grid to a fixed set of processor cores. Every core has a fixed number of residency slots. A block placed in a slot stays there until the owning core reports that slot complete, so blocks never move between cores. Blocks that do not fit wait in an implicit queue, which is just the next index to hand out.

A slot freed by a completion is refilled on a later clock by the next queued block. A grid smaller than the total slot count therefore leaves the higher-numbered cores idle. A larger grid drains in successive waves. Each dispatch is a single-cycle announcement carrying the core, the slot and the block index, and there is no handshake on it. When the last resident block completes and nothing is left to send, the block raises a one-cycle finish pulse and goes idle, ready for the next launch.

Top module: `blk_dispatch`

## Requirements
- R1: A core never holds more than SLOTS_PER_CORE blocks. A dispatch only targets a slot that is free in the cycle it is presented, and no dispatch is presented while every slot is occupied.
- R2: An occupied slot stays occupied, and is never re-dispatched, until its core pulses `cmpl_i[c]` with that slot's number on its field of `cmpl_slot_i`. Core c's field is bits [c*SLOT_W +: SLOT_W].
- R3: A slot released by a completion at clock edge n can receive a new block in the cycle that follows edge n.
- R4: A launch is accepted only while idle, with a grid of at least 1 block and a block size of 1 to 1024 threads (1 to 32 warps of 32 lanes). An idle launch that breaks these limits pulses `reject_o` in the following cycle and dispatches nothing. A launch made while busy is ignored and does not pulse `reject_o`.
- R5: Block indices go out in ascending order from 0 to grid size minus 1, with at most one dispatch per clock.
- R6: Each dispatch goes to the lowest-numbered core that has a free slot, and to the lowest-numbered free slot within that core.
- R7: `grid_done_o` pulses for exactly one cycle, in the cycle after the edge at which the final completion of the grid is taken. `busy_o` falls in that same cycle.
- R8: After reset the block is idle: `busy_o`, `disp_valid_o`, `grid_done_o` and `reject_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Launch request, sampled for one cycle |
| grid_blocks_i | input | GRID_W | Number of blocks in the grid |
| block_threads_i | input | THR_W | Threads per block |
| cmpl_i | input | NUM_CORES | Per-core block completion strobe |
| cmpl_slot_i | input | NUM_CORES*SLOT_W | Slot of the completed block, one field per core |
| disp_valid_o | output | 1 | A dispatch is committed at this clock edge |
| disp_core_o | output | CORE_W | Target core |
| disp_slot_o | output | SLOT_W | Target slot within the core |
| disp_block_o | output | GRID_W | Block index being dispatched |
| busy_o | output | 1 | A grid is in flight |
| grid_done_o | output | 1 | One-cycle pulse when the grid has finished |
| reject_o | output | 1 | One-cycle pulse for an invalid idle launch |

## Verification
The hardest state to reach is one where every slot is occupied and a grid larger than the total capacity is still queued. Only that state shows the stall, the exact slot that gets refilled after a scattered completion, and an ignored second launch. The stimulus reaches it by launching a 20-block grid, withholding all completions until all 16 slots fill, and issuing a launch during the stall. It then releases blocks at random from a model of residency kept in the bench. Randomly sized grids with random completion rates then vary the mix of refills and partial waves.

// File: rtl/bd_pkg.sv
package bd_pkg;
  localparam int unsigned MAX_BLOCK_THREADS = 1024;
  localparam int unsigned WARP_LANES        = 32;
endpackage

// File: rtl/bd_slot_table.sv
module bd_slot_table #(
  parameter int unsigned NUM_CORES      = 4,
  parameter int unsigned SLOTS_PER_CORE = 4,
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned SLOT_W = (SLOTS_PER_CORE > 1) ? $clog2(SLOTS_PER_CORE) : 1,
  localparam int unsigned NSLOT  = NUM_CORES * SLOTS_PER_CORE
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          set_i,
  input  logic [CORE_W-1:0]             set_core_i,
  input  logic [SLOT_W-1:0]             set_slot_i,
  input  logic [NUM_CORES-1:0]          clr_i,
  input  logic [NUM_CORES*SLOT_W-1:0]   clr_slot_i,
  output logic [NSLOT-1:0]              occ_o,
  output logic [NSLOT-1:0]              occ_nxt_o
);
  logic [NSLOT-1:0] occ_q;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar s = 0; s < SLOTS_PER_CORE; s++) begin : g_slot
      localparam int unsigned IDX = c * SLOTS_PER_CORE + s;
      logic set_b, clr_b;
      assign set_b = set_i && (set_core_i == CORE_W'(c)) && (set_slot_i == SLOT_W'(s));
      assign clr_b = clr_i[c] && (clr_slot_i[c*SLOT_W +: SLOT_W] == SLOT_W'(s));
      assign occ_nxt_o[IDX] = (occ_q[IDX] & ~clr_b) | set_b;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) occ_q[IDX] <= 1'b0;
        else         occ_q[IDX] <= occ_nxt_o[IDX];
      end
    end
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/bd_core_pick.sv
module bd_core_pick #(
  parameter int unsigned NUM_CORES      = 4,
  parameter int unsigned SLOTS_PER_CORE = 4,
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned SLOT_W = (SLOTS_PER_CORE > 1) ? $clog2(SLOTS_PER_CORE) : 1,
  localparam int unsigned NSLOT  = NUM_CORES * SLOTS_PER_CORE
) (
  input  logic [NSLOT-1:0]  occ_i,
  output logic              found_o,
  output logic [CORE_W-1:0] core_o,
  output logic [SLOT_W-1:0] slot_o
);
  // descending scan: last hit is lowest core, lowest slot
  always_comb begin
    found_o = 1'b0;
    core_o  = '0;
    slot_o  = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      for (int s = SLOTS_PER_CORE - 1; s >= 0; s--) begin
        if (!occ_i[c*SLOTS_PER_CORE + s]) begin
          found_o = 1'b1;
          core_o  = CORE_W'(c);
          slot_o  = SLOT_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/bd_grid_ctrl.sv
module bd_grid_ctrl
  import bd_pkg::*;
#(
  parameter int unsigned GRID_W = 16,
  parameter int unsigned THR_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [GRID_W-1:0] grid_blocks_i,
  input  logic [THR_W-1:0]  block_threads_i,
  input  logic              pick_found_i,
  input  logic              occ_any_i,
  input  logic              occ_nxt_any_i,
  output logic              fire_o,
  output logic [GRID_W-1:0] blk_o,
  output logic              busy_o,
  output logic              grid_done_o,
  output logic              reject_o
);
  logic              busy_q, done_q, rej_q;
  logic [GRID_W-1:0] blk_q, grid_q;
  logic              thr_ok, accept, fin;

  assign thr_ok = (block_threads_i != '0) && (32'(block_threads_i) <= MAX_BLOCK_THREADS);
  assign accept = launch_i && !busy_q && thr_ok && (grid_blocks_i != '0);
  assign fire_o = busy_q && (blk_q != grid_q) && pick_found_i;
  // queue drained and the last resident block leaves at this edge
  assign fin    = busy_q && (blk_q == grid_q) && occ_any_i && !occ_nxt_any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      blk_q  <= '0;
      grid_q <= '0;
    end else begin
      rej_q  <= launch_i && !busy_q && !accept;
      done_q <= fin;
      if (accept) begin
        busy_q <= 1'b1;
        blk_q  <= '0;
        grid_q <= grid_blocks_i;
      end else begin
        if (fire_o) blk_q  <= blk_q + 1'b1;
        if (fin)    busy_q <= 1'b0;
      end
    end
  end

  assign blk_o       = blk_q;
  assign busy_o      = busy_q;
  assign grid_done_o = done_q;
  assign reject_o    = rej_q;
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch #(
  parameter int unsigned NUM_CORES      = 4,
  parameter int unsigned SLOTS_PER_CORE = 4,
  parameter int unsigned GRID_W         = 16,
  parameter int unsigned THR_W          = 11,
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned SLOT_W = (SLOTS_PER_CORE > 1) ? $clog2(SLOTS_PER_CORE) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        launch_i,
  input  logic [GRID_W-1:0]           grid_blocks_i,
  input  logic [THR_W-1:0]            block_threads_i,
  input  logic [NUM_CORES-1:0]        cmpl_i,
  input  logic [NUM_CORES*SLOT_W-1:0] cmpl_slot_i,
  output logic                        disp_valid_o,
  output logic [CORE_W-1:0]           disp_core_o,
  output logic [SLOT_W-1:0]           disp_slot_o,
  output logic [GRID_W-1:0]           disp_block_o,
  output logic                        busy_o,
  output logic                        grid_done_o,
  output logic                        reject_o
);
  localparam int unsigned NSLOT = NUM_CORES * SLOTS_PER_CORE;

  logic [NSLOT-1:0]  occ_q, occ_nxt;
  logic              pick_found, fire;
  logic [CORE_W-1:0] pick_core;
  logic [SLOT_W-1:0] pick_slot;

  bd_core_pick #(.NUM_CORES(NUM_CORES), .SLOTS_PER_CORE(SLOTS_PER_CORE)) u_pick (
    .occ_i   (occ_q),
    .found_o (pick_found),
    .core_o  (pick_core),
    .slot_o  (pick_slot)
  );

  bd_slot_table #(.NUM_CORES(NUM_CORES), .SLOTS_PER_CORE(SLOTS_PER_CORE)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (fire),
    .set_core_i (pick_core),
    .set_slot_i (pick_slot),
    .clr_i      (cmpl_i),
    .clr_slot_i (cmpl_slot_i),
    .occ_o      (occ_q),
    .occ_nxt_o  (occ_nxt)
  );

  bd_grid_ctrl #(.GRID_W(GRID_W), .THR_W(THR_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .launch_i        (launch_i),
    .grid_blocks_i   (grid_blocks_i),
    .block_threads_i (block_threads_i),
    .pick_found_i    (pick_found),
    .occ_any_i       (|occ_q),
    .occ_nxt_any_i   (|occ_nxt),
    .fire_o          (fire),
    .blk_o           (disp_block_o),
    .busy_o          (busy_o),
    .grid_done_o     (grid_done_o),
    .reject_o        (reject_o)
  );

  assign disp_valid_o = fire;
  assign disp_core_o  = pick_core;
  assign disp_slot_o  = pick_slot;
endmodule

// File: rtl/bd_checker.sv
module bd_checker #(
  parameter int unsigned NUM_CORES      = 4,
  parameter int unsigned SLOTS_PER_CORE = 4,
  parameter int unsigned GRID_W         = 16,
  parameter int unsigned THR_W          = 11,
  localparam int unsigned CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned SLOT_W = (SLOTS_PER_CORE > 1) ? $clog2(SLOTS_PER_CORE) : 1,
  localparam int unsigned NSLOT  = NUM_CORES * SLOTS_PER_CORE
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        launch_i,
  input logic [THR_W-1:0]            block_threads_i,
  input logic [NUM_CORES-1:0]        cmpl_i,
  input logic [NUM_CORES*SLOT_W-1:0] cmpl_slot_i,
  input logic                        disp_valid_o,
  input logic [CORE_W-1:0]           disp_core_o,
  input logic [SLOT_W-1:0]           disp_slot_o,
  input logic [GRID_W-1:0]           disp_block_o,
  input logic                        busy_o,
  input logic                        grid_done_o,
  input logic                        reject_o,
  input logic [NSLOT-1:0]            occ_i
);
  logic [NSLOT-1:0] clr_m, kept;
  logic             tgt_busy, lower_free;

  always_comb begin
    clr_m      = '0;
    lower_free = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int s = 0; s < SLOTS_PER_CORE; s++) begin
        if (cmpl_i[c] && (int'(cmpl_slot_i[c*SLOT_W +: SLOT_W]) == s))
          clr_m[c*SLOTS_PER_CORE + s] = 1'b1;
        if (!occ_i[c*SLOTS_PER_CORE + s] &&
            ((c < int'(disp_core_o)) || ((c == int'(disp_core_o)) && (s < int'(disp_slot_o)))))
          lower_free = 1'b1;
      end
    end
    tgt_busy = occ_i[int'(disp_core_o)*SLOTS_PER_CORE + int'(disp_slot_o)];
  end
  assign kept = occ_i & ~clr_m;

  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> !tgt_busy);

  p_no_migrate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(kept) & ~occ_i) == '0));

  p_bad_launch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_i && !busy_o && ((block_threads_i == '0) || (32'(block_threads_i) > 32'd1024)))
    |=> (reject_o && !busy_o));

  p_ascending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |=> (!disp_valid_o || (disp_block_o == $past(disp_block_o) + 1'b1)));

  p_lowest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> !lower_free);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grid_done_o |-> ((occ_i == '0) && !busy_o && !disp_valid_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grid_done_o |=> !grid_done_o);
endmodule

bind blk_dispatch bd_checker #(
  .NUM_CORES(NUM_CORES), .SLOTS_PER_CORE(SLOTS_PER_CORE), .GRID_W(GRID_W), .THR_W(THR_W)
) u_bd_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .launch_i        (launch_i),
  .block_threads_i (block_threads_i),
  .cmpl_i          (cmpl_i),
  .cmpl_slot_i     (cmpl_slot_i),
  .disp_valid_o    (disp_valid_o),
  .disp_core_o     (disp_core_o),
  .disp_slot_o     (disp_slot_o),
  .disp_block_o    (disp_block_o),
  .busy_o          (busy_o),
  .grid_done_o     (grid_done_o),
  .reject_o        (reject_o),
  .occ_i           (occ_q)
);

// File: tb/blk_dispatch_tb_top.sv
`timescale 1ns/1ps
module blk_dispatch_tb_top;
  localparam int NC = 4;
  localparam int NS = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          launch;
  logic [15:0]   grid;
  logic [10:0]   thr;
  logic [NC-1:0] cmpl;
  logic [NC*SW-1:0] cmpl_slot;
  logic          disp_valid, busy, gdone, rej;
  logic [1:0]    disp_core, disp_slot;
  logic [15:0]   disp_block;

  int n_chk = 0;
  int n_bad = 0;

  bit m_occ [NC][NS];
  bit m_busy;
  int m_blk, m_grid;

  always #2.5 clk = ~clk;

  blk_dispatch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .launch_i(launch), .grid_blocks_i(grid),
    .block_threads_i(thr), .cmpl_i(cmpl), .cmpl_slot_i(cmpl_slot),
    .disp_valid_o(disp_valid), .disp_core_o(disp_core), .disp_slot_o(disp_slot),
    .disp_block_o(disp_block), .busy_o(busy), .grid_done_o(gdone), .reject_o(rej)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic bit launch_ok(input int g, input int t);
    return (g > 0) && (t >= 1) && (t <= 1024);
  endfunction

  // one cycle: entered and left at a falling edge
  task automatic step(input bit lch, input int lg, input int lt, input int pct);
    int ec = 0, es = 0;
    bit ef = 0, ev, acc, exp_rej, exp_done, had_occ = 0, any_occ = 0;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) begin
        if (!ef && !m_occ[c][s]) begin ef = 1; ec = c; es = s; end
        if (m_occ[c][s]) had_occ = 1;
      end
    ev = m_busy && (m_blk < m_grid) && ef;
    chk(disp_valid == ev, "R1 R5 dispatch valid", int'(disp_valid), int'(ev));
    if (ev && disp_valid) begin
      chk(int'(disp_core) == ec, "R6 core", int'(disp_core), ec);
      chk(int'(disp_slot) == es, "R3 R6 slot", int'(disp_slot), es);
      chk(int'(disp_block) == m_blk, "R5 block index", int'(disp_block), m_blk);
    end
    launch = lch;
    grid   = 16'(lg);
    thr    = 11'(lt);
    acc     = lch && !m_busy && launch_ok(lg, lt);
    exp_rej = lch && !m_busy && !acc;
    cmpl = '0;
    for (int c = 0; c < NC; c++) begin
      int cnt = 0;
      for (int s = 0; s < NS; s++) cnt += int'(m_occ[c][s]);
      if (cnt > 0 && int'($urandom_range(99)) < pct) begin
        int k = int'($urandom_range(NS - 1));
        while (!m_occ[c][k]) k = (k + 1) % NS;
        cmpl[c] = 1'b1;
        cmpl_slot[c*SW +: SW] = SW'(k);
        m_occ[c][k] = 0;
      end
    end
    if (ev) begin m_occ[ec][es] = 1; m_blk++; end
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) if (m_occ[c][s]) any_occ = 1;
    exp_done = m_busy && (m_blk == m_grid) && had_occ && !any_occ;
    if (exp_done) m_busy = 0;
    if (acc) begin m_busy = 1; m_blk = 0; m_grid = lg; end
    @(posedge clk);
    @(negedge clk);
    launch = 1'b0;
    cmpl   = '0;
    chk(gdone == exp_done, "R7 grid done", int'(gdone), int'(exp_done));
    chk(rej == exp_rej, "R4 reject", int'(rej), int'(exp_rej));
    chk(busy == m_busy, "R4 R7 busy", int'(busy), int'(m_busy));
  endtask

  task automatic drain(input int pct);
    int n = 0;
    while (m_busy && n < 5000) begin step(0, 0, 0, pct); n++; end
    chk(!m_busy, "R7 grid finished", int'(m_busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; launch = 1'b0; grid = '0; thr = '0; cmpl = '0; cmpl_slot = '0;
    m_busy = 0; m_blk = 0; m_grid = 0;
    foreach (m_occ[c, s]) m_occ[c][s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !disp_valid && !gdone && !rej, "R8 reset idle",
        int'({busy, disp_valid, gdone, rej}), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);

    // R4 invalid launches
    step(1, 5, 0, 0);
    step(1, 5, 1025, 0);
    step(1, 0, 64, 0);
    step(1, 3, 2047, 0);
    step(0, 0, 0, 0);

    // small grid, max block size: core 0 only
    step(1, 3, 1024, 0);
    repeat (6) step(0, 0, 0, 0);
    drain(100);

    // minimum block size, immediately after a finish
    step(1, 1, 1, 0);
    step(0, 0, 0, 0);
    drain(100);

    // grid over capacity: fill, stall, busy launch, then refill waves
    step(1, 20, 256, 0);
    repeat (20) step(0, 0, 0, 0);
    step(1, 5, 64, 0);
    step(0, 0, 0, 0);
    drain(40);

    // random launches
    for (int i = 0; i < 14; i++) begin
      int g = int'($urandom_range(60, 1));
      int t = int'($urandom_range(1024, 1));
      int p = int'($urandom_range(90, 10));
      step(1, g, t, 0);
      drain(p);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule